// File: doc/BRIEF.md
# Flash Read Accelerator Cache

This block sits between a processor's two read ports and a slow flash array. The instruction-fetch port and the data port each get their own direct-mapped cache of 128-bit lines. Vector-table reads are issued on the instruction port, so they share its cache. A read that hits answers on the next cycle. A read that misses makes the block request the whole line from the flash array. The array is held for a programmable number of wait states, then the line is written into that port's cache and the requested word is returned.

Both caches share the flash array through a small controller. When both ports miss together, the data port is served first. On the instruction side, each demand fill of line N is followed by a prefetch of line N+1, unless N+1 is already cached. This lets straight-line code find its next line ready. If the instruction port misses on some other line while the prefetch is running, the prefetch is abandoned and the array restarts on the demanded line. A request for the line being prefetched waits only for the rest of that access.

Top module: `fa_flash_accel`

## Requirements
- R1: The instruction port and the data port have separate caches. A line filled through one port is not visible to the other, which misses on it. Vector-table reads are ordinary instruction-port reads.
- R2: A read that hits raises its port's rvalid, with the word, in the cycle after the request cycle. Its ready output stays high.
- R3: For a wait-state setting W in 0..7, sampled when an array access starts, fl_addr presents the line for W+1 cycles. A demand miss that finds the array idle answers W+3 cycles after its request cycle. W=0 gives a single-cycle array access.
- R4: Addresses are word-aligned byte addresses. Bits [3:2] pick word k of the line, which is fl_line bits [32k+31:32k]. After a fill, the other three words of that line hit.
- R5: Each cache is direct-mapped with 64 lines, indexed by byte-address bits [9:4]. Two addresses that differ by 1024 bytes evict each other.
- R6: While a miss is outstanding on a port, that port's ready is low. Requests presented then are ignored and produce no response. The port returns only the missed word.
- R7: After an instruction demand fill of line N, line N+1 is prefetched unless it is already cached. A request for N+1 made G cycles after the fill's response waits W+2-G cycles when G <= W+1, and hits in 1 cycle otherwise. When N+1 was already cached, no prefetch occupies the array.
- R8: An instruction demand miss on a line other than the one being prefetched cancels the prefetch. It still answers W+3 cycles after its request cycle, and the cancelled line is not installed.
- R9: The array serves one fill at a time. When both ports miss in the same cycle, the data port answers after W+3 cycles and the instruction port after 2W+5 cycles.
- R10: During and after reset, both ready outputs are high, no rvalid is raised, and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wait_states | input | 3 | Array wait states per access, 0..7 |
| i_req | input | 1 | Instruction-port read request |
| i_addr | input | 20 | Instruction-port byte address |
| i_ready | output | 1 | Instruction port can accept a request |
| i_rvalid | output | 1 | Instruction read data valid |
| i_rdata | output | 32 | Instruction read data |
| d_req | input | 1 | Data-port read request |
| d_addr | input | 20 | Data-port byte address |
| d_ready | output | 1 | Data port can accept a request |
| d_rvalid | output | 1 | Data read data valid |
| d_rdata | output | 32 | Data read data |
| fl_addr | output | 16 | Line address presented to the flash array |
| fl_line | input | 128 | Line returned by the flash array for fl_addr |

## Verification
The hardest case to reach is an instruction request for line N+1 that arrives in exactly the cycle the prefetch of N+1 finishes. In that cycle the line is still being written and is not yet a hit, so the word must be taken straight from the returning fill. To land on that cycle, the bench sweeps the gap between a demand fill's response and the follow-up request from 0 to W+2 cycles, for every wait-state setting. One point of each sweep falls on the completion cycle, and its latency is predicted by formula. The same sweep structure times prefetch cancellation, port priority and the skipped prefetch through the data port's latency.

// File: rtl/fa_pkg.sv
package fa_pkg;
  localparam int LINE_W  = 128;
  localparam int WORD_W  = 32;
  localparam int WORDS   = LINE_W / WORD_W;
  localparam int OFF_W   = $clog2(WORDS);
  localparam int BYTE_W  = $clog2(WORD_W / 8);
  localparam int LOFF_W  = OFF_W + BYTE_W;
  localparam int PORT_I  = 0;
  localparam int PORT_D  = 1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MISS = 2'd1,
    ST_PF   = 2'd2
  } side_st_t;
endpackage

// File: rtl/fa_array_ctrl.sv
module fa_array_ctrl
  import fa_pkg::*;
#(
  parameter int LW  = 16,
  parameter int WSW = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [WSW-1:0]      ws_i,
  input  logic [1:0]          req_i,
  input  logic [1:0][LW-1:0]  line_i,
  output logic [1:0]          done_o,
  output logic [LW-1:0]       fl_addr_o
);
  logic           busy;
  logic           owner;
  logic [WSW-1:0] cnt;
  logic [WSW-1:0] ws_lat;
  logic [WSW-1:0] age;
  logic           same;
  logic           restart;
  logic           nxt_owner;

  assign same      = req_i[owner] && (line_i[owner] == fl_addr_o);
  assign restart   = busy && !same;
  assign nxt_owner = req_i[PORT_D] ? 1'b1 : 1'b0;

  for (genvar k = 0; k < 2; k++) begin : g_done
    assign done_o[k] = busy && (owner == 1'(k)) && same && (cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      owner     <= 1'b0;
      cnt       <= '0;
      ws_lat    <= '0;
      age       <= '0;
      fl_addr_o <= '0;
    end else if (!busy) begin
      if (|req_i) begin
        busy      <= 1'b1;
        owner     <= nxt_owner;
        fl_addr_o <= line_i[nxt_owner];
        cnt       <= ws_i;
        ws_lat    <= ws_i;
        age       <= '0;
      end
    end else if (restart) begin
      if (req_i[owner]) begin
        fl_addr_o <= line_i[owner];
        cnt       <= ws_i;
        ws_lat    <= ws_i;
        age       <= '0;
      end else begin
        busy <= 1'b0;
      end
    end else if (cnt == '0) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt - WSW'(1);
      age <= age + WSW'(1);
    end
  end

  AST_ONE_FILL: assert property (@(posedge clk) disable iff (rst)
    $onehot0(done_o));                                                    // R9
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && same && cnt != '0) |=> $stable(fl_addr_o));                  // R3
  AST_WAIT_LEN: assert property (@(posedge clk) disable iff (rst)
    (|done_o) |-> (age == ws_lat));                                       // R3
endmodule

// File: rtl/fa_port_cache.sv
module fa_port_cache
  import fa_pkg::*;
#(
  parameter int AW       = 20,
  parameter int LINES    = 64,
  parameter bit PREFETCH = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_i,
  input  logic [AW-1:0]        addr_i,
  output logic                 ready_o,
  output logic                 rvalid_o,
  output logic [WORD_W-1:0]    rdata_o,
  output logic                 arr_req_o,
  output logic [AW-LOFF_W-1:0] arr_line_o,
  input  logic                 fill_done_i,
  input  logic [LINE_W-1:0]    fill_line_i
);
  localparam int LW = AW - LOFF_W;
  localparam int IW = $clog2(LINES);
  localparam int TW = LW - IW;

  logic [LINE_W-1:0] data_mem [LINES];
  logic [TW-1:0]     tag_mem  [LINES];
  logic [LINES-1:0]  vld;

  side_st_t          st;
  logic [LW-1:0]     cur_line;
  logic [OFF_W-1:0]  cur_off;

  logic [LW-1:0]     req_line;
  logic [IW-1:0]     req_idx;
  logic [TW-1:0]     req_tag;
  logic [OFF_W-1:0]  req_off;
  logic [IW-1:0]     cur_idx;
  logic              hit;
  logic              accept;
  logic              fill_match;
  logic [WORD_W-1:0] hit_word;
  logic [WORD_W-1:0] fill_req_word;
  logic [WORD_W-1:0] fill_cur_word;
  logic              pf_go;
  logic [LW-1:0]     pf_line;

  assign req_line      = addr_i[AW-1:LOFF_W];
  assign req_idx       = req_line[IW-1:0];
  assign req_tag       = req_line[LW-1:IW];
  assign req_off       = addr_i[LOFF_W-1:BYTE_W];
  assign cur_idx       = cur_line[IW-1:0];
  assign hit           = vld[req_idx] && (tag_mem[req_idx] == req_tag);
  assign accept        = req_i && (st != ST_MISS);
  assign fill_match    = (st == ST_PF) && fill_done_i && (req_line == cur_line);
  assign hit_word      = data_mem[req_idx][{req_off, 5'b0} +: WORD_W];
  assign fill_req_word = fill_line_i[{req_off, 5'b0} +: WORD_W];
  assign fill_cur_word = fill_line_i[{cur_off, 5'b0} +: WORD_W];

  assign ready_o    = (st != ST_MISS);
  assign arr_req_o  = (st != ST_IDLE);
  assign arr_line_o = cur_line;

  if (PREFETCH) begin : g_pf
    logic [LW-1:0] nl;
    assign nl      = cur_line + LW'(1);
    assign pf_line = nl;
    assign pf_go   = !(vld[nl[IW-1:0]] && (tag_mem[nl[IW-1:0]] == nl[LW-1:IW]));
  end else begin : g_nopf
    assign pf_line = cur_line;
    assign pf_go   = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (fill_done_i) begin
      data_mem[cur_idx] <= fill_line_i;
      tag_mem[cur_idx]  <= cur_line[LW-1:IW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld      <= '0;
      st       <= ST_IDLE;
      cur_line <= '0;
      cur_off  <= '0;
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= 1'b0;
      if (fill_done_i) vld[cur_idx] <= 1'b1;
      if (st == ST_MISS) begin
        if (fill_done_i) begin
          rvalid_o <= 1'b1;
          rdata_o  <= fill_cur_word;
          if (pf_go) begin
            st       <= ST_PF;
            cur_line <= pf_line;
          end else begin
            st <= ST_IDLE;
          end
        end
      end else begin
        if ((st == ST_PF) && fill_done_i) st <= ST_IDLE;
        if (accept) begin
          if (hit) begin
            rvalid_o <= 1'b1;
            rdata_o  <= hit_word;
          end else if (fill_match) begin
            rvalid_o <= 1'b1;
            rdata_o  <= fill_req_word;
          end else begin
            st       <= ST_MISS;
            cur_line <= req_line;
            cur_off  <= req_off;
          end
        end
      end
    end
  end

  AST_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    req_i |-> (addr_i[BYTE_W-1:0] == '0));                                // R4
  AST_HIT_NEXT: assert property (@(posedge clk) disable iff (rst)
    (accept && hit) |=> rvalid_o);                                        // R2
  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (rst)
    (st == ST_MISS && !fill_done_i) |=> !rvalid_o);                       // R6
  AST_MISS_LINE_HELD: assert property (@(posedge clk) disable iff (rst)
    (st == ST_MISS && !fill_done_i) |=> $stable(cur_line));               // R6
  AST_FILL_ANSWERS: assert property (@(posedge clk) disable iff (rst)
    (st == ST_MISS && fill_done_i) |=> (rvalid_o && ready_o));            // R3
endmodule

// File: rtl/fa_flash_accel.sv
module fa_flash_accel
  import fa_pkg::*;
#(
  parameter int AW      = 20,
  parameter int I_LINES = 64,
  parameter int D_LINES = 64,
  parameter int WSW     = 3,
  localparam int LW     = AW - LOFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WSW-1:0]    wait_states,
  input  logic              i_req,
  input  logic [AW-1:0]     i_addr,
  output logic              i_ready,
  output logic              i_rvalid,
  output logic [WORD_W-1:0] i_rdata,
  input  logic              d_req,
  input  logic [AW-1:0]     d_addr,
  output logic              d_ready,
  output logic              d_rvalid,
  output logic [WORD_W-1:0] d_rdata,
  output logic [LW-1:0]     fl_addr,
  input  logic [LINE_W-1:0] fl_line
);
  logic [1:0]         arr_req;
  logic [1:0][LW-1:0] arr_line;
  logic [1:0]         done;

  fa_port_cache #(.AW(AW), .LINES(I_LINES), .PREFETCH(1'b1)) u_icache (
    .clk(clk), .rst(rst), .req_i(i_req), .addr_i(i_addr),
    .ready_o(i_ready), .rvalid_o(i_rvalid), .rdata_o(i_rdata),
    .arr_req_o(arr_req[PORT_I]), .arr_line_o(arr_line[PORT_I]),
    .fill_done_i(done[PORT_I]), .fill_line_i(fl_line)
  );

  fa_port_cache #(.AW(AW), .LINES(D_LINES), .PREFETCH(1'b0)) u_dcache (
    .clk(clk), .rst(rst), .req_i(d_req), .addr_i(d_addr),
    .ready_o(d_ready), .rvalid_o(d_rvalid), .rdata_o(d_rdata),
    .arr_req_o(arr_req[PORT_D]), .arr_line_o(arr_line[PORT_D]),
    .fill_done_i(done[PORT_D]), .fill_line_i(fl_line)
  );

  fa_array_ctrl #(.LW(LW), .WSW(WSW)) u_arr (
    .clk(clk), .rst(rst), .ws_i(wait_states), .req_i(arr_req),
    .line_i(arr_line), .done_o(done), .fl_addr_o(fl_addr)
  );
endmodule

// File: tb/fa_flash_accel_test.sv
module fa_flash_accel_test;
  localparam int AW = 20;
  localparam int LW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    ws = '0;
  logic          i_req = 1'b0, d_req = 1'b0;
  logic [AW-1:0] i_addr = '0, d_addr = '0;
  logic          i_ready, i_rvalid, d_ready, d_rvalid;
  logic [31:0]   i_rdata, d_rdata;
  logic [LW-1:0] fl_addr;
  logic [127:0]  fl_line;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  fa_flash_accel uut (
    .clk(clk), .rst(rst), .wait_states(ws),
    .i_req(i_req), .i_addr(i_addr), .i_ready(i_ready), .i_rvalid(i_rvalid), .i_rdata(i_rdata),
    .d_req(d_req), .d_addr(d_addr), .d_ready(d_ready), .d_rvalid(d_rvalid), .d_rdata(d_rdata),
    .fl_addr(fl_addr), .fl_line(fl_line)
  );

  function automatic logic [31:0] fw(input logic [AW-1:0] a);
    logic [31:0] x;
    x = 32'({a[AW-1:2], 2'b00});
    return (x * 32'h9E3779B1) ^ 32'h0F1E2D3C;
  endfunction

  always_comb begin
    for (int k = 0; k < 4; k++) fl_line[k*32 +: 32] = fw({fl_addr, 2'(k), 2'b00});
  end

  task automatic chk(input string r, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go(input bit ui, input logic [AW-1:0] ia, input bit ud, input logic [AW-1:0] da,
                    output int li, output int ld, output logic [31:0] di, output logic [31:0] dd);
    li = -1; ld = -1; di = '0; dd = '0;
    i_req = ui; i_addr = ia; d_req = ud; d_addr = da;
    for (int k = 1; k <= 80; k++) begin
      @(negedge clk);
      i_req = 1'b0; d_req = 1'b0;
      if (ui && li < 0 && i_rvalid) begin li = k; di = i_rdata; end
      if (ud && ld < 0 && d_rvalid) begin ld = k; dd = d_rdata; end
      if ((!ui || li >= 0) && (!ud || ld >= 0)) break;
    end
  endtask

  task automatic rd_i(input logic [AW-1:0] a, input int exp_lat, input string r);
    int li, ld; logic [31:0] di, dd;
    go(1'b1, a, 1'b0, '0, li, ld, di, dd);
    chk(r, "i latency", li, exp_lat);
    chk(r, "i data", di, fw(a));
  endtask

  task automatic rd_d(input logic [AW-1:0] a, input int exp_lat, input string r);
    int li, ld; logic [31:0] di, dd;
    go(1'b0, '0, 1'b1, a, li, ld, di, dd);
    chk(r, "d latency", ld, exp_lat);
    chk(r, "d data", dd, fw(a));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int li, ld, lat, wv;
    logic [31:0] di, dd;
    logic [AW-1:0] b, a;
    idle(3);
    chk("R10", "rvalid in reset", {i_rvalid, d_rvalid}, 0);
    rst = 1'b0;
    idle(1);
    chk("R10", "ready after reset", {i_ready, d_ready}, 2'b11);
    chk("R10", "rvalid after reset", {i_rvalid, d_rvalid}, 0);

    for (int w = 0; w < 8; w++) begin
      wv = w;
      ws = 3'(w);
      b = AW'(w * 32'h4000);
      idle(2);
      // R3 R4: data-port miss then the rest of the line
      rd_d(b + 20'h24, wv + 3, "R3");
      rd_d(b + 20'h20, 1, "R4");
      rd_d(b + 20'h28, 1, "R4");
      rd_d(b + 20'h2C, 1, "R2");
      // R1: instruction side does not see the data-side line
      rd_i(b + 20'h24, wv + 3, "R1");
      idle(40);
      // R7: follow-up request to line N+1 after a gap of g cycles
      for (int g = 0; g <= w + 2; g++) begin
        a = b + 20'h100 + AW'(g * 64);
        rd_i(a, wv + 3, "R3");
        idle(g);
        rd_i(a + 20'h10, (g <= wv + 1) ? (wv + 2 - g) : 1, "R7");
        idle(40);
      end
      // R8: prefetch cancelled by a miss to another line
      rd_i(b + 20'h800, wv + 3, "R3");
      rd_i(b + 20'hA00, wv + 3, "R8");
      idle(40);
      rd_i(b + 20'h810, wv + 3, "R8");
      idle(40);
      // R5: same index, 1024 bytes apart
      rd_d(b + 20'h1000, wv + 3, "R5");
      rd_d(b + 20'h1400, wv + 3, "R5");
      rd_d(b + 20'h1000, wv + 3, "R5");
      rd_d(b + 20'h1004, 1, "R5");
      idle(4);
      // R9: both ports miss together
      go(1'b1, b + 20'h2000, 1'b1, b + 20'h2840, li, ld, di, dd);
      chk("R9", "d latency", ld, wv + 3);
      chk("R9", "i latency", li, 2 * wv + 5);
      chk("R9", "d data", dd, fw(b + 20'h2840));
      chk("R9", "i data", di, fw(b + 20'h2000));
      idle(40);
      // R7: no prefetch when N+1 is cached, prefetch otherwise
      rd_i(b + 20'h3010, wv + 3, "R7");
      idle(40);
      rd_i(b + 20'h3000, wv + 3, "R7");
      rd_d(b + 20'h3800, wv + 3, "R7");
      idle(40);
      rd_i(b + 20'h3400, wv + 3, "R7");
      rd_d(b + 20'h3C00, 2 * wv + 4, "R7");
      idle(40);
      // R6: request changed while the miss is outstanding
      d_req = 1'b1; d_addr = b + 20'h1800;
      lat = -1;
      for (int k = 1; k <= 60; k++) begin
        @(negedge clk);
        if (k == 1) chk("R6", "ready during miss", d_ready, 0);
        d_addr = b + 20'h1C40;
        if (d_rvalid) begin
          lat = k;
          d_req = 1'b0;
          chk("R6", "held word", d_rdata, fw(b + 20'h1800));
          break;
        end
      end
      chk("R6", "latency", lat, wv + 3);
      lat = 0;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        if (d_rvalid) lat++;
      end
      chk("R6", "extra responses", lat, 0);
      rd_d(b + 20'h1C40, wv + 3, "R6");
      idle(4);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule